// File: doc/BRIEF.md
# Tag-Matched Custom Operation Unit

This functional unit sits beside a processor register file and executes application-defined operations. Each operation is named by an 11-bit identifier. The unit keeps a small set of resident slots, and each slot holds one identifier together with the fixed function it stands for.

When the processor issues an operation, the identifier is compared against every resident slot. On a hit, the result is computed combinationally from the live operand values. The result is returned in the same cycle once every operand that function needs is marked ready.

On a miss, the unit flags the miss and holds the processor in a stall. It loads the operation into a slot chosen round-robin over a fixed reload period, then completes the operation. The processor keeps `issue_i`, the identifier and the operands applied until `done_o` is seen.

Top module: `cop_unit`

## Requirements
- R1: After reset no slot is valid, so the first issue of any identifier raises `miss_o`.
- R2: A hit requires equality on all 11 identifier bits: an identifier that differs from a resident one only in bit 10 misses.
- R3: An issue that hits with all needed operands ready raises `done_o` with the result in that same cycle, and `stall_o` stays low.
- R4: An issue that hits while a needed operand's ready bit is low holds `stall_o` high with `done_o` low. It completes in the first cycle in which all needed ready bits are high.
- R5: A miss raises `miss_o` for exactly the issue cycle, then reloads for 4 cycles. `stall_o` is high for 5 cycles in total, and the operation completes in the next cycle if its operands are ready.
- R6: The function is chosen by identifier bits [1:0]: 0 gives a+b+c, 1 gives a-b, 2 gives (a&b)|c, 3 gives (a<<b[4:0])^c. All results wrap to 32 bits.
- R7: Function 1 needs only operands a and b, so the ready bit of operand c (src_rdy_i[2]) has no effect on its completion.
- R8: Four operations can be resident at once. After four distinct identifiers are loaded, each of them hits without stalling.
- R9: Reload replaces slots in round-robin order starting at slot 0. With four slots full, a fifth identifier evicts the oldest-loaded one, and the others stay resident.
- R10: The unit holds no data between operations: the same identifier and operands always give the same result.
- R11: With `issue_i` low, `done_o`, `stall_o` and `miss_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | A custom operation is being issued |
| op_tag_i | input | 11 | Identifier of the issued operation |
| src_a_i | input | 32 | Operand a, live register value |
| src_b_i | input | 32 | Operand b, live register value |
| src_c_i | input | 32 | Operand c, live register value |
| src_rdy_i | input | 3 | Ready bits: bit0 a, bit1 b, bit2 c |
| stall_o | output | 1 | Hold the pipeline |
| miss_o | output | 1 | Issued identifier is not resident |
| done_o | output | 1 | Result valid this cycle |
| result_o | output | 32 | Operation result |

## Verification
The hardest state to reach is round-robin eviction with a full set of slots. Getting there takes four distinct misses, each with its full reload. A fifth miss must then land on an identifier that differs from a resident one in the top bit only. The directed sequence loads four identifiers in known order and confirms that all of them hit. It then issues that top-bit neighbour and probes which identifiers still hit and which miss. Late operands are produced by holding one ready bit low for a counted number of cycles, and the stall cycles are compared against that count.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int SRC_N = 3;

  typedef enum logic [1:0] {
    FN_SUM3  = 2'd0,
    FN_SUB   = 2'd1,
    FN_ANDOR = 2'd2,
    FN_SHXOR = 2'd3
  } fn_e;

  // operands each function actually consumes (bit0 a, bit1 b, bit2 c)
  function automatic logic [SRC_N-1:0] fn_needs(fn_e f);
    return (f == FN_SUB) ? 3'b011 : 3'b111;
  endfunction
endpackage

// File: rtl/cop_slots.sv
module cop_slots
  import cop_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int TAG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] lookup_tag_i,
  output logic             hit_o,
  output fn_e              hit_fn_o,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic             vld_q [SLOTS];
  logic [TAG_W-1:0] tag_q [SLOTS];
  fn_e              fn_q  [SLOTS];
  logic [SLOTS-1:0] match;
  logic [PTR_W-1:0] rr_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
        fn_q[s]  <= FN_SUM3;
      end else if (wr_en_i && rr_q == PTR_W'(s)) begin
        vld_q[s] <= 1'b1;
        tag_q[s] <= wr_tag_i;
        fn_q[s]  <= fn_e'(wr_tag_i[1:0]);
      end
    end
    assign match[s] = vld_q[s] && (tag_q[s] == lookup_tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rr_q <= '0;
    else if (wr_en_i) rr_q <= (rr_q == PTR_W'(SLOTS-1)) ? '0 : rr_q + 1'b1;
  end

  assign hit_o = |match;

  always_comb begin
    hit_fn_o = FN_SUM3;
    for (int s = 0; s < SLOTS; s++)
      if (match[s]) hit_fn_o = fn_q[s];
  end

  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R8

  AST_WR_IS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !match[rr_q]); // R9
endmodule

// File: rtl/cop_eval.sv
module cop_eval
  import cop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fn_e              fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [SRC_N-1:0]  rdy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ops_rdy_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SRC_N-1:0] need;

  assign need      = fn_needs(fn_i);
  assign ops_rdy_o = &(rdy_i | ~need);

  always_comb begin
    unique case (fn_i)
      FN_SUM3:  res_o = a_i + b_i + c_i;
      FN_SUB:   res_o = a_i - b_i;
      FN_ANDOR: res_o = (a_i & b_i) | c_i;
      default:  res_o = (a_i << b_i[SH_W-1:0]) ^ c_i;
    endcase
  end
endmodule

// File: rtl/cop_reload.sv
module cop_reload #(
  parameter int TAG_W      = 11,
  parameter int RELOAD_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             busy_o,
  output logic             wr_en_o,
  output logic [TAG_W-1:0] wr_tag_o
);
  localparam int CNT_W = (RELOAD_CYC > 1) ? $clog2(RELOAD_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tag_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RELOAD_CYC-1);
      tag_q  <= tag_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign wr_en_o  = busy_q && (cnt_q == '0);
  assign wr_tag_o = tag_q;

  AST_MISS_STARTS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R5

  AST_LOAD_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !busy_o); // R5

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R5
endmodule

// File: rtl/cop_unit.sv
module cop_unit
  import cop_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int TAG_W      = 11,
  parameter int DATA_W     = 32,
  parameter int RELOAD_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [TAG_W-1:0]  op_tag_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] src_c_i,
  input  logic [SRC_N-1:0]  src_rdy_i,
  output logic              stall_o,
  output logic              miss_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  logic             hit, busy, wr_en, ops_rdy;
  logic [TAG_W-1:0] wr_tag;
  fn_e              hit_fn;

  cop_slots #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lookup_tag_i (op_tag_i),
    .hit_o        (hit),
    .hit_fn_o     (hit_fn),
    .wr_en_i      (wr_en),
    .wr_tag_i     (wr_tag)
  );

  cop_eval #(.DATA_W(DATA_W)) u_eval (
    .fn_i      (hit_fn),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .c_i       (src_c_i),
    .rdy_i     (src_rdy_i),
    .res_o     (result_o),
    .ops_rdy_o (ops_rdy)
  );

  cop_reload #(.TAG_W(TAG_W), .RELOAD_CYC(RELOAD_CYC)) u_reload (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (miss_o),
    .tag_i    (op_tag_i),
    .busy_o   (busy),
    .wr_en_o  (wr_en),
    .wr_tag_o (wr_tag)
  );

  assign miss_o  = issue_i && !hit && !busy;
  assign done_o  = issue_i && hit && ops_rdy && !busy;
  assign stall_o = issue_i && !done_o;

  AST_LOAD_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && issue_i) |-> stall_o); // R5

  AST_LATE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !ops_rdy) |-> !done_o); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> !(done_o || stall_o || miss_o)); // R11

  AST_MISS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && issue_i) |=> !miss_o); // R5
endmodule

// File: tb/sim_cop_unit.sv
`timescale 1ns/1ps
module sim_cop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [10:0] tag = '0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [2:0]  rdy = '0;
  logic        stall, miss, done;
  logic [31:0] result;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cop_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_tag_i(tag),
    .src_a_i(a), .src_b_i(b), .src_c_i(c), .src_rdy_i(rdy),
    .stall_o(stall), .miss_o(miss), .done_o(done), .result_o(result)
  );

  function automatic logic [31:0] ref_fn(logic [10:0] t, logic [31:0] x, y, z);
    case (t[1:0])
      2'd0:    return x + y + z;
      2'd1:    return x - y;
      2'd2:    return (x & y) | z;
      default: return (x << y[4:0]) ^ z;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // issue one op; operand c held not-ready for 'late' stall cycles
  task automatic run_op(logic [10:0] t, logic [31:0] x, y, z, int late,
                        int exp_stall, int exp_miss, string req);
    int stalls = 0, misses = 0;
    @(negedge clk);
    issue = 1'b1; tag = t; a = x; b = y; c = z;
    rdy = (late > 0) ? 3'b011 : 3'b111;
    #1;
    while (!done && stalls < 40) begin
      if (miss) misses++;
      if (stall) stalls++;
      @(negedge clk);
      if (stalls >= late) rdy = 3'b111;
      #1;
    end
    chk(done === 1'b1, req, "done seen", {31'd0, done}, 32'd1);
    chk(result === ref_fn(t, x, y, z), req, "result", result, ref_fn(t, x, y, z));
    chk(stalls == exp_stall, req, "stall cycles", stalls, exp_stall);
    chk(misses == exp_miss, req, "miss cycles", misses, exp_miss);
    @(negedge clk);
    issue = 1'b0; rdy = '0;
  endtask

  task automatic t_idle(string req);
    @(negedge clk); #1;
    chk({done, stall, miss} === 3'b000, req, "idle outputs", {29'd0, done, stall, miss}, 0);
  endtask

  task automatic t_reset;
    t_idle("R11");
    run_op(11'h100, 32'd5, 32'd6, 32'd7, 0, 5, 1, "R1");
  endtask

  task automatic t_hit;
    run_op(11'h100, 32'hFFFF_FFFF, 32'd2, 32'd3, 0, 0, 0, "R3");
    run_op(11'h100, 32'h1234, 32'h10, 32'h1, 0, 0, 0, "R10");
    run_op(11'h100, 32'h1234, 32'h10, 32'h1, 0, 0, 0, "R10");
  endtask

  task automatic t_fill;
    run_op(11'h101, 32'd3, 32'd9, 32'd0, 0, 5, 1, "R6");
    run_op(11'h102, 32'hF0F0, 32'hFF00, 32'h000F, 0, 5, 1, "R6");
    run_op(11'h103, 32'h8000_0001, 32'd33, 32'h55, 0, 5, 1, "R6");
    run_op(11'h100, 32'd1, 32'd1, 32'd1, 0, 0, 0, "R8");
    run_op(11'h101, 32'd1, 32'd2, 32'd0, 0, 0, 0, "R8");
    run_op(11'h102, 32'd7, 32'd3, 32'd8, 0, 0, 0, "R8");
    run_op(11'h103, 32'd1, 32'd4, 32'd2, 0, 0, 0, "R8");
  endtask

  task automatic t_late;
    run_op(11'h102, 32'hAA, 32'h0F, 32'h100, 2, 2, 0, "R4");
    run_op(11'h103, 32'h3, 32'h1, 32'h0, 3, 3, 0, "R4");
    run_op(11'h101, 32'd50, 32'd8, 32'hDEAD, 3, 0, 0, "R7");
  endtask

  task automatic t_evict;
    run_op(11'h500, 32'd2, 32'd2, 32'd2, 0, 5, 1, "R2");
    run_op(11'h101, 32'd9, 32'd4, 32'd0, 0, 0, 0, "R9");
    run_op(11'h100, 32'd4, 32'd4, 32'd4, 0, 5, 1, "R9");
    run_op(11'h102, 32'd1, 32'd2, 32'd4, 0, 0, 0, "R9");
    run_op(11'h101, 32'd9, 32'd4, 32'd0, 0, 5, 1, "R9");
    t_idle("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit();
    t_fill();
    t_late();
    t_evict();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule